// File: doc/BRIEF.md
# Serial Line Transceiver with Programmable Framing

This block is a full-duplex asynchronous serial transceiver. It sits between an internal command processor and a pair of serial pins. Bytes for transmission arrive on a valid/ready stream. Received bytes leave on a second valid/ready stream. The line format is set at run time through three small configuration registers: bit period in clock cycles, data-bit count and stop-bit count. Parity, flow control and FIFOs are not part of the block.

The bit period is the system clock frequency divided by the baud rate. With a 50 MHz clock, 9600 baud needs 5208 and 256000 baud needs 195. The transmitter and the receiver each take a snapshot of the configuration when a character starts. A register write made while a character is on the line therefore only affects the next character. The receiver brings the line in through two flops and checks the start bit again half a bit period later. It then samples every data bit at its centre.

Top module: `uart_prog`

## Requirements
- R1: After reset the bit period reads 5208 (50 MHz / 9600), the data-bit count reads 8 and the stop-bit count reads 1. `txd` is high, `tx_ready` is high, and `rx_valid` and `frame_err` are low.
- R2: The registers sit at these offsets: bit period at 0x10, data-bit count at 0x11, stop-bit count at 0x12. `cfg_rdata` gives the current value of the register that `cfg_addr` selects, zero-extended. Any other offset reads 0. A bit-period write takes the low 16 bits of `cfg_wdata`.
- R3: A bit-period write below 4 stores 4.
- R4: A data-bit write outside 5..8 is ignored, and so is a stop-bit write outside 1..2. The old value stays.
- R5: A transmitted character is one low start bit, then N data bits least significant first, then S high stop bits. Each bit lasts one bit period. `tx_ready` is low for exactly (1+N+S) bit periods after the accepting edge.
- R6: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. While the transmitter is idle, `txd` is high.
- R7: A received character is sampled least significant bit first at the centre of each bit. It is presented on `rx_data` as its N bits, zero-extended. A low pulse shorter than half a bit period does not start a character.
- R8: `rx_valid` rises when a good character completes. It stays high until a cycle where `rx_ready` is high.
- R9: If the line is low when the first stop bit is sampled, the character is dropped and `frame_err` goes high. `frame_err` then stays high until reset.
- R10: A configuration write made during a character does not change that character. It applies from the next character on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the addressed register (combinational) |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmitter idle, can accept a byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Consumer takes the received byte |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
A register read is due in the same cycle, since `cfg_rdata` is combinational. The bench reads it one time step after it sets the address on a falling edge. The transmitter output is indexed by the number of falling edges after the accepting clock edge. Bit k is due at index k·P + P/2, and `tx_ready` returns at index (1+N+S)·P, so every sample falls at the centre of a bit. The bench checks received bytes a few cycles after it finishes driving the stop bits. By then the two sync flops and the half-period centre sample have settled, and `rx_valid` is sampled there and again after a consumer pulse.

// File: rtl/uart_prog_pkg.sv
package uart_prog_pkg;

    localparam int DIV_W  = 16;
    localparam int NBIT_W = 4;
    localparam int BYTE_W = 8;

    localparam logic [7:0] ADDR_DIV   = 8'h10;
    localparam logic [7:0] ADDR_NBITS = 8'h11;
    localparam logic [7:0] ADDR_NSTOP = 8'h12;

    localparam logic [DIV_W-1:0] DIV_MIN = 16'd4;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [NBIT_W-1:0] nbits;
        logic [1:0]        nstop;
    } line_cfg_t;

    typedef enum logic [2:0] {
        LN_IDLE, LN_START, LN_DATA, LN_STOP, LN_BREAK
    } line_state_t;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
        return (v < DIV_MIN) ? DIV_MIN : v;
    endfunction

endpackage

// File: rtl/uart_prog_regs.sv
module uart_prog_regs
    import uart_prog_pkg::*;
#(
    parameter logic [DIV_W-1:0] RESET_DIV = 16'd5208
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output line_cfg_t   cfg
);
    logic unused_hi;
    assign unused_hi = ^cfg_wdata[31:DIV_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.div   <= RESET_DIV;
            cfg.nbits <= 4'd8;
            cfg.nstop <= 2'd1;
        end else if (cfg_wr) begin
            case (cfg_addr)
                ADDR_DIV:   cfg.div <= clamp_div(cfg_wdata[DIV_W-1:0]);
                ADDR_NBITS: if (cfg_wdata >= 32'd5 && cfg_wdata <= 32'd8)
                                cfg.nbits <= cfg_wdata[NBIT_W-1:0];
                ADDR_NSTOP: if (cfg_wdata == 32'd1 || cfg_wdata == 32'd2)
                                cfg.nstop <= cfg_wdata[1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (cfg_addr)
            ADDR_DIV:   cfg_rdata = {{(32-DIV_W){1'b0}}, cfg.div};
            ADDR_NBITS: cfg_rdata = {{(32-NBIT_W){1'b0}}, cfg.nbits};
            ADDR_NSTOP: cfg_rdata = {30'd0, cfg.nstop};
            default:    cfg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/uart_prog_tx.sv
module uart_prog_tx
    import uart_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_cfg_t         cfg,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd
);
    line_state_t       state;
    line_cfg_t         act;
    logic [DIV_W-1:0]  cnt;
    logic [NBIT_W-1:0] bitn;
    logic [BYTE_W-1:0] sh;
    logic              bit_end;

    assign bit_end = (cnt == act.div - 16'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LN_IDLE;
            act   <= '0;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
        end else begin
            case (state)
                LN_IDLE: if (tx_valid) begin
                    act   <= cfg;
                    sh    <= tx_data;
                    cnt   <= '0;
                    state <= LN_START;
                end
                LN_START: if (bit_end) begin
                    cnt   <= '0;
                    bitn  <= '0;
                    state <= LN_DATA;
                end else cnt <= cnt + 16'd1;
                LN_DATA: if (bit_end) begin
                    cnt <= '0;
                    sh  <= sh >> 1;
                    if (bitn == act.nbits - 4'd1) begin
                        bitn  <= '0;
                        state <= LN_STOP;
                    end else bitn <= bitn + 4'd1;
                end else cnt <= cnt + 16'd1;
                LN_STOP: if (bit_end) begin
                    cnt <= '0;
                    if (bitn == {2'b00, act.nstop} - 4'd1) state <= LN_IDLE;
                    else bitn <= bitn + 4'd1;
                end else cnt <= cnt + 16'd1;
                default: state <= LN_IDLE;
            endcase
        end
    end

    assign tx_ready = (state == LN_IDLE);
    assign txd      = (state == LN_START) ? 1'b0 :
                      (state == LN_DATA)  ? sh[0] : 1'b1;
endmodule

// File: rtl/uart_prog_rx.sv
module uart_prog_rx
    import uart_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_cfg_t         cfg,
    input  logic              rxd,
    input  logic              rx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err
);
    logic [1:0]        sync;
    logic              rxs;
    line_state_t       state;
    line_cfg_t         act;
    logic [DIV_W-1:0]  cnt;
    logic [NBIT_W-1:0] bitn;
    logic [BYTE_W-1:0] sh;
    logic              bit_end, half_end, good_stop;

    assign rxs       = sync[1];
    assign bit_end   = (cnt == act.div - 16'd1);
    assign half_end  = (cnt == (act.div >> 1) - 16'd1);
    assign good_stop = (state == LN_STOP) && bit_end && rxs;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync      <= 2'b11;
            state     <= LN_IDLE;
            act       <= '0;
            cnt       <= '0;
            bitn      <= '0;
            sh        <= '0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            sync <= {sync[0], rxd};
            if (good_stop) begin
                rx_valid <= 1'b1;
                rx_data  <= sh >> (4'd8 - act.nbits);
            end else if (rx_ready) rx_valid <= 1'b0;
            case (state)
                LN_IDLE: if (!rxs) begin
                    act   <= cfg;
                    cnt   <= '0;
                    state <= LN_START;
                end
                LN_START: if (half_end) begin
                    cnt   <= '0;
                    bitn  <= '0;
                    state <= rxs ? LN_IDLE : LN_DATA;
                end else cnt <= cnt + 16'd1;
                LN_DATA: if (bit_end) begin
                    cnt <= '0;
                    sh  <= {rxs, sh[BYTE_W-1:1]};
                    if (bitn == act.nbits - 4'd1) state <= LN_STOP;
                    else bitn <= bitn + 4'd1;
                end else cnt <= cnt + 16'd1;
                LN_STOP: if (bit_end) begin
                    cnt <= '0;
                    if (rxs) state <= LN_IDLE;
                    else begin
                        frame_err <= 1'b1;
                        state     <= LN_BREAK;
                    end
                end else cnt <= cnt + 16'd1;
                LN_BREAK: if (rxs) state <= LN_IDLE;
                default: state <= LN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_prog.sv
module uart_prog
    import uart_prog_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [7:0]  tx_data,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic        txd,
    input  logic        rxd,
    output logic [7:0]  rx_data,
    output logic        rx_valid,
    input  logic        rx_ready,
    output logic        frame_err
);
    localparam logic [DIV_W-1:0] RESET_DIV = DIV_W'(CLK_HZ / BAUD);

    line_cfg_t cfg;

    uart_prog_regs #(.RESET_DIV(RESET_DIV)) u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg(cfg)
    );

    uart_prog_tx u_tx (
        .clk(clk), .rst(rst), .cfg(cfg), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd)
    );

    uart_prog_rx u_rx (
        .clk(clk), .rst(rst), .cfg(cfg), .rxd(rxd), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err)
    );
endmodule

// File: rtl/uart_prog_chk.sv
module uart_prog_chk
    import uart_prog_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [7:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        txd,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic        frame_err
);
    logic unused_hi;
    assign unused_hi = ^cfg_wdata[31:DIV_W];

    assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);

    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_ready) |-> $past(tx_valid));

    assert_hold_valid_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> rx_valid);

    assert_sticky_err_R9: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err);

    assert_div_readback_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == ADDR_DIV && cfg_wdata[DIV_W-1:0] >= DIV_MIN)
        ##1 (cfg_addr == ADDR_DIV)
        |-> cfg_rdata == {16'd0, $past(cfg_wdata[DIV_W-1:0])});
endmodule

bind uart_prog uart_prog_chk u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .frame_err(frame_err)
);

// File: tb/uart_prog_bench.sv
module uart_prog_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready, txd;
    logic        rxd = 1'b1;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b0;
    logic        frame_err;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    uart_prog u_uart_prog (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .frame_err(frame_err)
    );

    function automatic logic [7:0] frame_mask(input int n);
        return 8'((1 << n) - 1);
    endfunction

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic set_line(input int div, input int n, input int s);
        cfg_write(8'h10, 32'(div));
        cfg_write(8'h11, 32'(n));
        cfg_write(8'h12, 32'(s));
    endtask

    // Sends one byte and decodes txd by falling-edge index after the accept edge.
    task automatic tx_frame(input logic [7:0] b, input int n, input int s, input int div,
                            input int chg_at, input int chg_div, input string req);
        logic [7:0] got = 8'h00;
        int j = 0;
        logic stop_ok = 1'b1;
        logic start_ok = 1'b1;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = b; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        while (!tx_ready && j < 4000) begin
            cfg_wr = 1'b0;
            if (j == chg_at) begin
                cfg_wr = 1'b1; cfg_addr = 8'h10; cfg_wdata = 32'(chg_div);
            end
            if (j == div / 2 && txd !== 1'b0) start_ok = 1'b0;
            for (int k = 0; k < n; k++)
                if (j == (1 + k) * div + div / 2) got[k] = txd;
            for (int k = 0; k < s; k++)
                if (j == (1 + n + k) * div + div / 2 && txd !== 1'b1) stop_ok = 1'b0;
            @(negedge clk);
            j++;
        end
        cfg_wr = 1'b0;
        check_eq({req, " start bit low"}, 32'(start_ok), 32'd1);
        check_eq({req, " data bits LSB first"}, 32'(got), 32'(b & frame_mask(n)));
        check_eq({req, " stop bits high"}, 32'(stop_ok), 32'd1);
        check_eq({req, " frame length"}, 32'(j), 32'((1 + n + s) * div));
    endtask

    task automatic rx_send(input logic [7:0] b, input int n, input int s, input int div,
                           input logic stop_level);
        @(negedge clk);
        rxd = 1'b0;
        repeat (div) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            rxd = b[k];
            repeat (div) @(negedge clk);
        end
        rxd = stop_level;
        repeat (div) @(negedge clk);
        rxd = 1'b1;
        repeat ((s - 1) * div + 4) @(negedge clk);
    endtask

    task automatic consume(input string req);
        @(negedge clk);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        check_eq({req, " valid cleared by ready"}, 32'(rx_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cfg_read(8'h10, rd); check_eq("R1 divider", rd, 32'd5208);
        cfg_read(8'h11, rd); check_eq("R1 data bits", rd, 32'd8);
        cfg_read(8'h12, rd); check_eq("R1 stop bits", rd, 32'd1);
        check_eq("R1 txd", 32'(txd), 32'd1);
        check_eq("R1 tx_ready", 32'(tx_ready), 32'd1);
        check_eq("R1 rx_valid", 32'(rx_valid), 32'd0);
        check_eq("R1 frame_err", 32'(frame_err), 32'd0);

        // R2 offsets and low-16 divider
        cfg_write(8'h10, 32'hABCD_0010);
        cfg_read(8'h10, rd); check_eq("R2 divider low half", rd, 32'h10);
        cfg_read(8'h13, rd); check_eq("R2 unmapped offset", rd, 32'd0);
        // R3 clamp
        cfg_write(8'h10, 32'd2);
        cfg_read(8'h10, rd); check_eq("R3 divider clamp", rd, 32'd4);
        // R4 ignored writes
        cfg_write(8'h11, 32'd9);
        cfg_read(8'h11, rd); check_eq("R4 data bits 9 ignored", rd, 32'd8);
        cfg_write(8'h11, 32'd4);
        cfg_read(8'h11, rd); check_eq("R4 data bits 4 ignored", rd, 32'd8);
        cfg_write(8'h12, 32'd3);
        cfg_read(8'h12, rd); check_eq("R4 stop bits 3 ignored", rd, 32'd1);
        cfg_write(8'h12, 32'd0);
        cfg_read(8'h12, rd); check_eq("R4 stop bits 0 ignored", rd, 32'd1);

        // R5 / R6 transmit
        set_line(16, 8, 1);
        tx_frame(8'hA5, 8, 1, 16, -1, 0, "R5 8N1");
        check_eq("R6 txd idle high", 32'(txd), 32'd1);
        set_line(12, 5, 2);
        tx_frame(8'hFF, 5, 2, 12, -1, 0, "R5 5N2");

        // R7 / R8 receive
        set_line(16, 8, 1);
        rx_send(8'h3C, 8, 1, 16, 1'b1);
        check_eq("R8 valid after stop", 32'(rx_valid), 32'd1);
        check_eq("R7 byte", 32'(rx_data), 32'h3C);
        repeat (20) @(negedge clk);
        check_eq("R8 valid held", 32'(rx_valid), 32'd1);
        consume("R8");
        set_line(10, 6, 2);
        rx_send(8'hEB, 6, 2, 10, 1'b1);
        check_eq("R7 six-bit byte", 32'(rx_data), 32'(8'hEB & frame_mask(6)));
        consume("R8");

        // R7 glitch shorter than half a bit
        set_line(16, 8, 1);
        @(negedge clk); rxd = 1'b0;
        repeat (3) @(negedge clk); rxd = 1'b1;
        repeat (200) @(negedge clk);
        check_eq("R7 glitch ignored", 32'(rx_valid), 32'd0);

        // R9 framing error
        rx_send(8'h55, 8, 1, 16, 1'b0);
        check_eq("R9 flag set", 32'(frame_err), 32'd1);
        check_eq("R9 byte dropped", 32'(rx_valid), 32'd0);
        rx_send(8'h81, 8, 1, 16, 1'b1);
        check_eq("R9 flag sticky", 32'(frame_err), 32'd1);
        check_eq("R9 next byte ok", 32'(rx_data), 32'h81);
        consume("R9");

        // R10 change during a character
        tx_frame(8'h96, 8, 1, 16, 40, 24, "R10 old period kept");
        tx_frame(8'h69, 8, 1, 24, -1, 0, "R10 new period used");

        // Random mix
        for (int it = 0; it < 8; it++) begin
            int div = 8 + int'($urandom % 13);
            int n   = 5 + int'($urandom % 4);
            int s   = 1 + int'($urandom % 2);
            logic [7:0] b = 8'($urandom);
            set_line(div, n, s);
            tx_frame(b, n, s, div, -1, 0, "R5 random");
            rx_send(~b, n, s, div, 1'b1);
            check_eq("R7 random byte", 32'(rx_data), 32'((~b) & frame_mask(n)));
            check_eq("R8 random valid", 32'(rx_valid), 32'd1);
            consume("R8");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule